// File: doc/BRIEF.md
# Condition flag status register

This block holds the condition state of a small 8-bit accumulator core in one 8-bit register. It keeps four condition codes (carry, half carry, zero, negative), a global interrupt mask bit and a flag that shows a nonvolatile memory write is in progress. On each clock it takes the result of the arithmetic unit, that unit's carry/borrow and nibble carry outputs, and a set of per-flag update strobes from the instruction decoder. Only the strobed flags change.

The carry flag has its own small operation selector. It can take the ALU carry, be loaded with a value, be inverted, or take part in a one-bit rotate. For the rotate, the block also forms the rotated data word from the current carry, so multi-byte shifts can be chained through it. The interrupt sequencer drives three mask hooks: set by instruction, set on return from interrupt, and clear on interrupt entry. The write-busy level from the memory controller is registered into its own bit.

Top module: `cond_flags_reg`

## Requirements
- R1: After the asynchronous active-low reset, `sr_o` reads 0x00. This includes the interrupt mask bit.
- R2: When `upd_c_i` is high and `cop_i` is 2'd0 (ALU), bit 0 (carry) takes `cout_i` on the next clock edge. `cout_i` is 1 for an add carry and for a subtract borrow, meaning the unsigned minuend is less than the subtrahend.
- R3: When `upd_h_i` is high, bit 1 (half carry) takes `hc_i`, the carry across the low/high nibble boundary.
- R4: When `upd_z_i` is high, bit 2 (zero) is set if `res_i` is zero and cleared otherwise.
- R5: When `upd_n_i` is high, bit 3 (negative) takes the most significant bit of `res_i`.
- R6: A flag whose update strobe is low keeps its value, whatever the data inputs are.
- R7: When `upd_c_i` is high and `cop_i` is 2'd1 (load), the carry takes `ld_c_i`.
- R8: When `upd_c_i` is high and `cop_i` is 2'd2 (invert), the carry takes its own complement.
- R9: Left rotate (`rot_dir_i`=0). `rot_res_o` is `{rot_src_i[6:0], carry}` at all times. With `upd_c_i` high and `cop_i` = 2'd3, the carry then takes `rot_src_i[7]`.
- R10: Right rotate (`rot_dir_i`=1). `rot_res_o` is `{carry, rot_src_i[7:1]}`. With `upd_c_i` high and `cop_i` = 2'd3, the carry then takes `rot_src_i[0]`.
- R11: Bit 4 (interrupt mask) is set by `g_set_i` or `g_reti_i` and cleared by `g_int_i`. When both a set and a clear arrive in the same cycle, the clear wins.
- R12: Bit 5 (write flag) takes `wr_busy_i` on each clock edge.
- R13: Bits 7:6 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_i | input | 8 | ALU result for zero and negative |
| cout_i | input | 1 | ALU carry or borrow out |
| hc_i | input | 1 | ALU nibble carry out |
| upd_c_i | input | 1 | Carry update strobe |
| upd_h_i | input | 1 | Half carry update strobe |
| upd_z_i | input | 1 | Zero update strobe |
| upd_n_i | input | 1 | Negative update strobe |
| cop_i | input | 2 | Carry operation: 0 ALU, 1 load, 2 invert, 3 rotate |
| ld_c_i | input | 1 | Value for carry load |
| rot_dir_i | input | 1 | Rotate direction: 0 left, 1 right |
| rot_src_i | input | 8 | Word to rotate through carry |
| g_set_i | input | 1 | Set mask by instruction |
| g_reti_i | input | 1 | Set mask on return from interrupt |
| g_int_i | input | 1 | Clear mask on interrupt entry |
| wr_busy_i | input | 1 | Memory write in progress |
| sr_o | output | 8 | Status register |
| rot_res_o | output | 8 | Rotated word with carry shifted in |

## Verification
The hardest case to reach from the ports is the rotate chain. The rotated word depends on a carry value left behind by an earlier operation, and the new carry depends on the far end of the source word. The stimulus first loads a known carry. It then rotates a word whose shifted-out bit differs from that carry. The combinational rotated word is checked before the clock edge and the new carry after it, in both directions. The mask clear-over-set conflict is also forced in one cycle, to show that interrupt entry wins.

// File: rtl/cond_flags_pkg.sv
package cond_flags_pkg;
  localparam int SR_W  = 8;
  localparam int BIT_C = 0;
  localparam int BIT_H = 1;
  localparam int BIT_Z = 2;
  localparam int BIT_N = 3;
  localparam int BIT_G = 4;
  localparam int BIT_R = 5;

  typedef enum logic [1:0] {
    COP_ALU  = 2'd0,
    COP_LOAD = 2'd1,
    COP_INV  = 2'd2,
    COP_ROT  = 2'd3
  } carry_op_e;
endpackage

// File: rtl/cf_carry_unit.sv
module cf_carry_unit
  import cond_flags_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          c_q_i,
  input  logic          upd_i,
  input  carry_op_e     cop_i,
  input  logic          cout_i,
  input  logic          ld_i,
  input  logic          dir_i,
  input  logic [DW-1:0] src_i,
  output logic          c_d_o,
  output logic [DW-1:0] rot_o
);
  logic out_bit;

  always_comb begin
    if (dir_i) begin
      rot_o   = {c_q_i, src_i[DW-1:1]};
      out_bit = src_i[0];
    end else begin
      rot_o   = {src_i[DW-2:0], c_q_i};
      out_bit = src_i[DW-1];
    end
  end

  always_comb begin
    c_d_o = c_q_i;
    if (upd_i) begin
      unique case (cop_i)
        COP_ALU:  c_d_o = cout_i;
        COP_LOAD: c_d_o = ld_i;
        COP_INV:  c_d_o = ~c_q_i;
        COP_ROT:  c_d_o = out_bit;
        default:  c_d_o = c_q_i;
      endcase
    end
  end
endmodule

// File: rtl/cf_result_flags.sv
module cf_result_flags #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] res_i,
  input  logic          hc_i,
  input  logic          upd_h_i,
  input  logic          upd_z_i,
  input  logic          upd_n_i,
  input  logic          h_q_i,
  input  logic          z_q_i,
  input  logic          n_q_i,
  output logic          h_d_o,
  output logic          z_d_o,
  output logic          n_d_o
);
  logic res_zero;
  assign res_zero = (res_i == '0);

  assign h_d_o = upd_h_i ? hc_i         : h_q_i;
  assign z_d_o = upd_z_i ? res_zero     : z_q_i;
  assign n_d_o = upd_n_i ? res_i[DW-1]  : n_q_i;
endmodule

// File: rtl/cf_mask_ctrl.sv
module cf_mask_ctrl (
  input  logic g_q_i,
  input  logic set_i,
  input  logic reti_i,
  input  logic int_i,
  output logic g_d_o
);
  // interrupt entry dominates any same-cycle set
  always_comb begin
    if (int_i)               g_d_o = 1'b0;
    else if (set_i || reti_i) g_d_o = 1'b1;
    else                     g_d_o = g_q_i;
  end
endmodule

// File: rtl/cond_flags_reg.sv
module cond_flags_reg
  import cond_flags_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] res_i,
  input  logic          cout_i,
  input  logic          hc_i,
  input  logic          upd_c_i,
  input  logic          upd_h_i,
  input  logic          upd_z_i,
  input  logic          upd_n_i,
  input  logic [1:0]    cop_i,
  input  logic          ld_c_i,
  input  logic          rot_dir_i,
  input  logic [DW-1:0] rot_src_i,
  input  logic          g_set_i,
  input  logic          g_reti_i,
  input  logic          g_int_i,
  input  logic          wr_busy_i,
  output logic [SR_W-1:0] sr_o,
  output logic [DW-1:0] rot_res_o
);
  logic [SR_W-1:0] sr_q, sr_d;
  logic c_d, h_d, z_d, n_d, g_d;

  cf_carry_unit #(.DW(DW)) u_carry (
    .c_q_i  (sr_q[BIT_C]),
    .upd_i  (upd_c_i),
    .cop_i  (carry_op_e'(cop_i)),
    .cout_i (cout_i),
    .ld_i   (ld_c_i),
    .dir_i  (rot_dir_i),
    .src_i  (rot_src_i),
    .c_d_o  (c_d),
    .rot_o  (rot_res_o)
  );

  cf_result_flags #(.DW(DW)) u_res (
    .res_i   (res_i),
    .hc_i    (hc_i),
    .upd_h_i (upd_h_i),
    .upd_z_i (upd_z_i),
    .upd_n_i (upd_n_i),
    .h_q_i   (sr_q[BIT_H]),
    .z_q_i   (sr_q[BIT_Z]),
    .n_q_i   (sr_q[BIT_N]),
    .h_d_o   (h_d),
    .z_d_o   (z_d),
    .n_d_o   (n_d)
  );

  cf_mask_ctrl u_mask (
    .g_q_i  (sr_q[BIT_G]),
    .set_i  (g_set_i),
    .reti_i (g_reti_i),
    .int_i  (g_int_i),
    .g_d_o  (g_d)
  );

  always_comb begin
    sr_d        = '0;
    sr_d[BIT_C] = c_d;
    sr_d[BIT_H] = h_d;
    sr_d[BIT_Z] = z_d;
    sr_d[BIT_N] = n_d;
    sr_d[BIT_G] = g_d;
    sr_d[BIT_R] = wr_busy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/cond_flags_reg_chk.sv
module cond_flags_reg_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] res_i,
  input logic          cout_i,
  input logic          upd_c_i,
  input logic          upd_z_i,
  input logic          upd_n_i,
  input logic [1:0]    cop_i,
  input logic          g_set_i,
  input logic          g_reti_i,
  input logic          g_int_i,
  input logic          wr_busy_i,
  input logic [7:0]    sr_o
);
  assert_carry_alu_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_c_i && cop_i == 2'd0) |=> sr_o[0] == $past(cout_i));

  assert_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_z_i |=> sr_o[2] == ($past(res_i) == '0));

  assert_neg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_n_i |=> sr_o[3] == $past(res_i[DW-1]));

  assert_carry_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_c_i |=> $stable(sr_o[0]));

  assert_carry_inv_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_c_i && cop_i == 2'd2) |=> sr_o[0] != $past(sr_o[0]));

  assert_mask_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g_int_i |=> !sr_o[4]);

  assert_mask_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!g_int_i && (g_set_i || g_reti_i)) |=> sr_o[4]);

  assert_wr_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sr_o[5] == $past(wr_busy_i));

  assert_upper_zero_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_o[7:6] == 2'b00);
endmodule

bind cond_flags_reg cond_flags_reg_chk #(.DW(DW)) u_chk (.*);

// File: tb/cond_flags_reg_test.sv
module cond_flags_reg_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] res_i = '0;
  logic       cout_i = 0, hc_i = 0;
  logic       upd_c_i = 0, upd_h_i = 0, upd_z_i = 0, upd_n_i = 0;
  logic [1:0] cop_i = '0;
  logic       ld_c_i = 0, rot_dir_i = 0;
  logic [7:0] rot_src_i = '0;
  logic       g_set_i = 0, g_reti_i = 0, g_int_i = 0, wr_busy_i = 0;
  logic [7:0] sr_o, rot_res_o;

  int n_chk = 0;
  int n_bad = 0;

  cond_flags_reg uut (.*);

  always #4 clk_i = ~clk_i;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    res_i = '0; cout_i = 0; hc_i = 0;
    upd_c_i = 0; upd_h_i = 0; upd_z_i = 0; upd_n_i = 0;
    cop_i = 2'd0; ld_c_i = 0; rot_dir_i = 0; rot_src_i = '0;
    g_set_i = 0; g_reti_i = 0; g_int_i = 0;
  endtask

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  task automatic t_reset();
    check("R1 reset", sr_o, 8'h00);
    check("R13 upper bits", {6'b0, sr_o[7:6]}, 8'h00);
  endtask

  task automatic t_alu();
    res_i = 8'h00; cout_i = 1; hc_i = 1;
    upd_c_i = 1; upd_h_i = 1; upd_z_i = 1; upd_n_i = 1;
    cyc();
    check("R2 R3 R4 carry half zero", sr_o, 8'h07);
    res_i = 8'h80; cout_i = 0; hc_i = 0;
    cyc();
    check("R5 negative, R4 zero cleared", sr_o, 8'h08);
    idle();
  endtask

  task automatic t_hold();
    res_i = 8'h00; cout_i = 1; hc_i = 1; ld_c_i = 1;
    cyc();
    check("R6 strobes low hold", sr_o, 8'h08);
    idle();
  endtask

  task automatic t_load();
    upd_c_i = 1; cop_i = 2'd1; ld_c_i = 1; cout_i = 0;
    cyc();
    check("R7 load 1", sr_o, 8'h09);
    ld_c_i = 0; cout_i = 1;
    cyc();
    check("R7 load 0", sr_o, 8'h08);
    idle();
  endtask

  task automatic t_inv();
    upd_c_i = 1; cop_i = 2'd2;
    cyc();
    check("R8 invert 0->1", sr_o, 8'h09);
    cyc();
    check("R8 invert 1->0", sr_o, 8'h08);
    idle();
  endtask

  task automatic t_rot();
    upd_c_i = 1; cop_i = 2'd1; ld_c_i = 1;
    cyc();
    idle();
    rot_src_i = 8'h55; rot_dir_i = 0; cop_i = 2'd3;
    #1;
    check("R9 left word", rot_res_o, 8'hAB);
    upd_c_i = 1;
    cyc();
    check("R9 left carry out", sr_o, 8'h08);
    rot_src_i = 8'h81; rot_dir_i = 1;
    #1;
    check("R10 right word", rot_res_o, 8'h40);
    cyc();
    check("R10 right carry out", sr_o, 8'h09);
    idle();
  endtask

  task automatic t_mask();
    g_set_i = 1;
    cyc();
    check("R11 set", sr_o, 8'h19);
    g_set_i = 0; g_int_i = 1;
    cyc();
    check("R11 int clear", sr_o, 8'h09);
    g_int_i = 0; g_reti_i = 1;
    cyc();
    check("R11 reti set", sr_o, 8'h19);
    g_reti_i = 0; g_int_i = 1; g_set_i = 1;
    cyc();
    check("R11 clear wins", sr_o, 8'h09);
    idle();
  endtask

  task automatic t_wr();
    wr_busy_i = 1;
    cyc();
    check("R12 write flag set", sr_o, 8'h29);
    check("R13 upper bits", {6'b0, sr_o[7:6]}, 8'h00);
    wr_busy_i = 0;
    cyc();
    check("R12 write flag clear", sr_o, 8'h09);
  endtask

  task automatic t_rerst();
    g_set_i = 1;
    cyc();
    idle();
    rst_ni = 0; #1;
    check("R1 reset mid-run", sr_o, 8'h00);
    cyc();
    rst_ni = 1;
  endtask

  initial begin
    idle();
    #20;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1;
    cyc();
    t_alu();
    t_hold();
    t_load();
    t_inv();
    t_rot();
    t_mask();
    t_wr();
    t_rerst();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule